// File: doc/BRIEF.md
# Compare/Capture PWM Timer Channel

This block is a single up-counting timer channel with two compare/capture slots, A and B, and two waveform outputs. The count advances on a selectable tick: an internal tick input or rising edges of an external event pin. The event pin is first passed through a two-flop synchronizer and an edge detector, so all logic stays in the system clock domain. Each slot is either a comparator, which raises a match event when a counting step leaves a count equal to its value, or a capture register, which latches the count on a rising edge of the capture pin. Slot B in comparator mode also sets the counting period. A plain register port configures the channel and reads back its state. Interrupt flags are cleared by writing ones, and each flag reaches the interrupt line only through its enable bit.

The counter is governed by a three-state machine. IDLE is entered whenever the run bit is 0. RUN is entered when run is 1 and no clock gating applies. FROZEN is entered when run is 1 and a gating condition holds: debug halt with the debug-run bit clear, or sleep with the sleep-stop bit set. The transitions are IDLE→RUN (start), IDLE→FROZEN (start while gated), RUN→FROZEN (gate), FROZEN→RUN (ungate), and RUN/FROZEN→IDLE (stop). The count steps only in RUN and is never cleared by gating.

Each output has its own waveform machine with states LOW, HIGH and SPENT. The transitions are LOW→HIGH (set or toggle), HIGH→LOW (clear or toggle), HIGH→SPENT (one-shot end) and SPENT→HIGH (toggle). Every state falls to LOW on the generation mode "off" or while the counter is IDLE. An invert bit is applied to each output after its machine.

Top module: `cct_timer_ch`

Register map (addresses on `bus_addr`): 0 control, 1 slot configuration, 2 slot A value, 3 slot B value, 4 flags, 5 interrupt enables, 6 count.

## Requirements
- R1: After reset, every register, the count, both outputs and `irq` read 0.
- R2: Control bit 0 is run, and bits 2:1 are the source select. With run=1 and source 00, each cycle with `int_tick` high advances the count by one. With run=0, the count holds. A write to address 6 loads the count.
- R3: With source 01, the count advances once per rising edge of `ext_evt` after a two-flop synchronizer; a long high level counts once, and `int_tick` is ignored.
- R4: Source 10 and source 11 never advance the count.
- R5: With slot B in comparator mode, a step from a count equal to slot B's value goes to 0 (period B+1). With slot B capturing, the count wraps from 16'hFFFF to 0.
- R6: Flag bit 0 (bit 1) is set when a counting step leaves a count equal to slot A (slot B) in comparator mode.
- R7: Configuration bit 0 (bit 1) puts slot A (slot B) in capture mode. In capture mode, a synchronized rising edge of `cap_in` while counting is allowed latches the count into that slot and sets flag bit 2 (bit 3). If that capture flag was already set, flag bit 4 (overrun) is also set.
- R8: If a configuration write sets both capture bits, only slot A captures, and bit 1 reads back 0.
- R9: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. `irq` is the OR of the flags masked by the enables at address 5 (same bit positions).
- R10: Control bit 3 is debug-run. While `debug_halt`=1 with debug-run=0, the count freezes. With debug-run=1, the count keeps advancing.
- R11: Control bit 4 is sleep-stop. While `sleep_req`=1 with sleep-stop=1, the count freezes and later resumes from the held value. With sleep-stop=0, sleep has no effect.
- R12: Output mode fields are configuration bits 3:2 (output A) and 6:5 (output B). Mode 00 holds the output inactive. Mode 01 sets the output on a slot A match and clears it on a slot B match, with clear winning. Mode 10 toggles output A on a slot A match and output B on a slot B match.
- R13: Mode 11 is a one-shot: the output rises on the first slot A match, falls on the next slot B match, and then stays low until run is cleared.
- R14: Configuration bit 4 (output A) and bit 7 (output B) invert the output after the mode logic, so mode 00 with invert=1 drives 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address for write and read |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| int_tick | input | 1 | Internal count tick |
| ext_evt | input | 1 | External event pin (asynchronous) |
| cap_in | input | 1 | Capture trigger pin (asynchronous) |
| sleep_req | input | 1 | Sleep mode indication |
| debug_halt | input | 1 | Debug mode indication |
| tout_a | output | 1 | Waveform output A |
| tout_b | output | 1 | Waveform output B |
| irq | output | 1 | Interrupt request |

## Verification
A register write takes effect at the clock edge it is sampled on. A change of run, source or gating inputs reaches the counter state one edge later. The bench therefore leaves two idle cycles after configuring before it pulses `int_tick`. A tick high across an edge updates the count, the flags and both outputs at that same edge, and the bench reads them at the following falling edge. Pins `ext_evt` and `cap_in` act at the third edge after they rise, so they are held high three cycles and followed by four idle cycles before any read. Waveform and count expectations come from bench functions that step the counter model one tick at a time.

// File: rtl/cct_pkg.sv
package cct_pkg;
    localparam int ADDR_W = 3;
    localparam int OUT_N  = 2;
    localparam int FLAG_N = 5;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_CFG  = 3'd1;
    localparam logic [ADDR_W-1:0] A_CCA  = 3'd2;
    localparam logic [ADDR_W-1:0] A_CCB  = 3'd3;
    localparam logic [ADDR_W-1:0] A_FLAG = 3'd4;
    localparam logic [ADDR_W-1:0] A_IEN  = 3'd5;
    localparam logic [ADDR_W-1:0] A_CNT  = 3'd6;

    localparam int FL_CMPA = 0;
    localparam int FL_CMPB = 1;
    localparam int FL_CAPA = 2;
    localparam int FL_CAPB = 3;
    localparam int FL_OVR  = 4;

    localparam logic [1:0] SRC_TICK = 2'b00;
    localparam logic [1:0] SRC_EXT  = 2'b01;

    localparam logic [1:0] WM_OFF     = 2'b00;
    localparam logic [1:0] WM_PWM     = 2'b01;
    localparam logic [1:0] WM_TOGGLE  = 2'b10;
    localparam logic [1:0] WM_ONESHOT = 2'b11;

    typedef enum logic [1:0] {
        CNT_IDLE   = 2'd0,
        CNT_RUN    = 2'd1,
        CNT_FROZEN = 2'd2
    } cnt_state_e;

    typedef enum logic [1:0] {
        WV_LOW   = 2'd0,
        WV_HIGH  = 2'd1,
        WV_SPENT = 2'd2
    } wave_state_e;

    typedef struct packed {
        logic       slp_stop;
        logic       dbg_run;
        logic [1:0] src;
        logic       run;
    } ctrl_t;

    typedef struct packed {
        logic       inv_b;
        logic [1:0] mode_b;
        logic       inv_a;
        logic [1:0] mode_a;
        logic       cap_b;
        logic       cap_a;
    } cfg_t;
endpackage

// File: rtl/cct_sync_edge.sv
module cct_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [STAGES:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[STAGES-1:0], din};
    end

    always_comb rise = pipe_q[STAGES-1] & ~pipe_q[STAGES];

    // R3
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/cct_counter.sv
module cct_counter import cct_pkg::*; #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         gate,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         wrap_en,
    input  logic [W-1:0] wrap_val,
    output logic [W-1:0] cnt,
    output logic         step,
    output cnt_state_e   state
);
    cnt_state_e   st_q, st_n;
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CNT_IDLE;
        else        st_q <= st_n;
    end

    always_comb begin
        st_n = st_q;
        unique case (st_q)
            CNT_IDLE:   if (run) st_n = gate ? CNT_FROZEN : CNT_RUN;
            CNT_RUN:    if (!run) st_n = CNT_IDLE;
                        else if (gate) st_n = CNT_FROZEN;
            CNT_FROZEN: if (!run) st_n = CNT_IDLE;
                        else if (!gate) st_n = CNT_RUN;
            default:    st_n = CNT_IDLE;
        endcase
    end

    always_comb begin
        step  = (st_q == CNT_RUN) && tick;
        state = st_q;
        cnt   = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             cnt_q <= '0;
        else if (load)                          cnt_q <= load_val;
        else if (step && wrap_en && cnt_q == wrap_val) cnt_q <= '0;
        else if (step)                          cnt_q <= cnt_q + 1'b1;
    end

    // R10 R11
    frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CNT_FROZEN && !load) |=> cnt_q == $past(cnt_q));
    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CNT_IDLE && !load) |=> cnt_q == $past(cnt_q));
    // R5
    period_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && wrap_en && cnt_q == wrap_val && !load) |=> cnt_q == '0);
endmodule

// File: rtl/cct_wavegen.sv
module cct_wavegen import cct_pkg::*; (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idle,
    input  logic [1:0] mode,
    input  logic       inv,
    input  logic       set_ev,
    input  logic       clr_ev,
    input  logic       tog_ev,
    output logic       wave
);
    wave_state_e st_q, st_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= WV_LOW;
        else        st_q <= st_n;
    end

    always_comb begin
        st_n = st_q;
        if (idle) begin
            st_n = WV_LOW;
        end else begin
            unique case (mode)
                WM_OFF:    st_n = WV_LOW;
                WM_PWM:    if (clr_ev) st_n = WV_LOW;
                           else if (set_ev) st_n = WV_HIGH;
                WM_TOGGLE: if (tog_ev) st_n = (st_q == WV_HIGH) ? WV_LOW : WV_HIGH;
                WM_ONESHOT: begin
                    unique case (st_q)
                        WV_LOW:   if (set_ev) st_n = WV_HIGH;
                        WV_HIGH:  if (clr_ev) st_n = WV_SPENT;
                        WV_SPENT: st_n = WV_SPENT;
                        default:  st_n = WV_LOW;
                    endcase
                end
                default:   st_n = WV_LOW;
            endcase
        end
    end

    always_comb wave = ((mode != WM_OFF) && (st_q == WV_HIGH)) ^ inv;

    // R13
    spent_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == WV_SPENT && mode == WM_ONESHOT && !idle) |=> st_q == WV_SPENT);
    // R13
    idle_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle |=> st_q == WV_LOW);
endmodule

// File: rtl/cct_regs.sv
module cct_regs import cct_pkg::*; #(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [W-1:0]      cnt,
    input  logic              match_a,
    input  logic              match_b,
    input  logic              cap_a_ev,
    input  logic              cap_b_ev,
    output ctrl_t             ctrl,
    output cfg_t              cfg,
    output logic [W-1:0]      cca,
    output logic [W-1:0]      ccb,
    output logic              irq
);
    ctrl_t             ctrl_q;
    cfg_t              cfg_q, cfg_in;
    logic [W-1:0]      cca_q, ccb_q;
    logic [FLAG_N-1:0] flag_q, ien_q, set_v, clr_v;

    always_comb begin
        cfg_in       = cfg_t'(bus_wdata[$bits(cfg_t)-1:0]);
        cfg_in.cap_b = cfg_in.cap_b & ~cfg_in.cap_a;
        set_v           = '0;
        set_v[FL_CMPA]  = match_a;
        set_v[FL_CMPB]  = match_b;
        set_v[FL_CAPA]  = cap_a_ev;
        set_v[FL_CAPB]  = cap_b_ev;
        set_v[FL_OVR]   = (cap_a_ev & flag_q[FL_CAPA]) | (cap_b_ev & flag_q[FL_CAPB]);
        clr_v = (bus_wr && bus_addr == A_FLAG) ? bus_wdata[FLAG_N-1:0] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            cfg_q  <= '0;
            cca_q  <= '0;
            ccb_q  <= '0;
            ien_q  <= '0;
            flag_q <= '0;
        end else begin
            if (bus_wr && bus_addr == A_CTRL) ctrl_q <= ctrl_t'(bus_wdata[$bits(ctrl_t)-1:0]);
            if (bus_wr && bus_addr == A_CFG)  cfg_q  <= cfg_in;
            if (bus_wr && bus_addr == A_IEN)  ien_q  <= bus_wdata[FLAG_N-1:0];
            if (cap_a_ev)                           cca_q <= cnt;
            else if (bus_wr && bus_addr == A_CCA)   cca_q <= bus_wdata;
            if (cap_b_ev)                           ccb_q <= cnt;
            else if (bus_wr && bus_addr == A_CCB)   ccb_q <= bus_wdata;
            flag_q <= (flag_q & ~clr_v) | set_v;
        end
    end

    always_comb begin
        case (bus_addr)
            A_CTRL:  bus_rdata = W'(ctrl_q);
            A_CFG:   bus_rdata = W'(cfg_q);
            A_CCA:   bus_rdata = cca_q;
            A_CCB:   bus_rdata = ccb_q;
            A_FLAG:  bus_rdata = W'(flag_q);
            A_IEN:   bus_rdata = W'(ien_q);
            A_CNT:   bus_rdata = cnt;
            default: bus_rdata = '0;
        endcase
        ctrl = ctrl_q;
        cfg  = cfg_q;
        cca  = cca_q;
        ccb  = ccb_q;
        irq  = |(flag_q & ien_q);
    end

    // R8
    single_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_q.cap_a && cfg_q.cap_b));
    // R9
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_FLAG && bus_wdata[FL_CMPA] && !match_a) |=> !flag_q[FL_CMPA]);
    // R7
    overrun_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_a_ev && flag_q[FL_CAPA]) |=> flag_q[FL_OVR]);
    // R7
    capture_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_a_ev |=> cca_q == $past(cnt));
endmodule

// File: rtl/cct_timer_ch.sv
module cct_timer_ch import cct_pkg::*; #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic              int_tick,
    input  logic              ext_evt,
    input  logic              cap_in,
    input  logic              sleep_req,
    input  logic              debug_halt,
    output logic              tout_a,
    output logic              tout_b,
    output logic              irq
);
    ctrl_t            ctrl;
    cfg_t             cfg;
    cnt_state_e       cstate;
    logic [CNT_W-1:0] cnt, cca, ccb;
    logic             ext_rise, cap_rise, gate, tick, step, load;
    logic             match_a, match_b, cap_a_ev, cap_b_ev, running, idle;
    logic [1:0]       wmode [OUT_N];
    logic             winv  [OUT_N];
    logic             wtog  [OUT_N];
    logic             wave  [OUT_N];

    cct_sync_edge #(.STAGES(SYNC_STAGES)) u_ext_sync (
        .clk(clk), .rst_n(rst_n), .din(ext_evt), .rise(ext_rise));

    cct_sync_edge #(.STAGES(SYNC_STAGES)) u_cap_sync (
        .clk(clk), .rst_n(rst_n), .din(cap_in), .rise(cap_rise));

    always_comb begin
        gate = (debug_halt & ~ctrl.dbg_run) | (sleep_req & ctrl.slp_stop);
        case (ctrl.src)
            SRC_TICK: tick = int_tick;
            SRC_EXT:  tick = ext_rise;
            default:  tick = 1'b0;
        endcase
        load     = bus_wr && bus_addr == A_CNT;
        running  = cstate == CNT_RUN;
        idle     = cstate == CNT_IDLE;
        match_a  = step && !cfg.cap_a && cnt == cca;
        match_b  = step && !cfg.cap_b && cnt == ccb;
        cap_a_ev = cap_rise && running && cfg.cap_a;
        cap_b_ev = cap_rise && running && cfg.cap_b;
        wmode[0] = cfg.mode_a;
        wmode[1] = cfg.mode_b;
        winv[0]  = cfg.inv_a;
        winv[1]  = cfg.inv_b;
        wtog[0]  = match_a;
        wtog[1]  = match_b;
    end

    cct_regs #(.W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cnt(cnt), .match_a(match_a), .match_b(match_b),
        .cap_a_ev(cap_a_ev), .cap_b_ev(cap_b_ev),
        .ctrl(ctrl), .cfg(cfg), .cca(cca), .ccb(ccb), .irq(irq));

    cct_counter #(.W(CNT_W)) u_counter (
        .clk(clk), .rst_n(rst_n), .run(ctrl.run), .gate(gate), .tick(tick),
        .load(load), .load_val(bus_wdata), .wrap_en(!cfg.cap_b), .wrap_val(ccb),
        .cnt(cnt), .step(step), .state(cstate));

    for (genvar g = 0; g < OUT_N; g++) begin : g_wave
        cct_wavegen u_wave (
            .clk(clk), .rst_n(rst_n), .idle(idle), .mode(wmode[g]), .inv(winv[g]),
            .set_ev(match_a), .clr_ev(match_b), .tog_ev(wtog[g]), .wave(wave[g]));
    end

    always_comb begin
        tout_a = wave[0];
        tout_b = wave[1];
    end

    // R4
    no_count_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.src[1] && !load) |=> cnt == $past(cnt));
endmodule

// File: tb/cct_timer_ch_test.sv
module cct_timer_ch_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0, bus_rdata;
    logic        int_tick = 1'b0, ext_evt = 1'b0, cap_in = 1'b0;
    logic        sleep_req = 1'b0, debug_halt = 1'b0;
    logic        tout_a, tout_b, irq;

    int checks = 0, failures = 0;
    logic [15:0] v, start, top;
    int          n;
    logic [1:0]  ma, mb;
    logic        ia, ib;
    logic [15:0] va, vb, mc;
    int          sa, sb;
    logic        ea, eb;

    always #(CLK_PERIOD/2) clk = ~clk;

    cct_timer_ch uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .int_tick(int_tick),
        .ext_evt(ext_evt), .cap_in(cap_in), .sleep_req(sleep_req),
        .debug_halt(debug_halt), .tout_a(tout_a), .tout_b(tout_b), .irq(irq));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk); bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic idle(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic tick(input int k);
        repeat (k) begin
            @(negedge clk); int_tick = 1'b1;
            @(negedge clk); int_tick = 1'b0;
        end
    endtask

    task automatic pulse_ext(input int k);
        repeat (k) begin
            @(negedge clk); ext_evt = 1'b1; idle(3); ext_evt = 1'b0; idle(3);
        end
        idle(4);
    endtask

    task automatic pulse_cap();
        @(negedge clk); cap_in = 1'b1; idle(3); cap_in = 1'b0; idle(4);
    endtask

    function automatic logic [15:0] exp_count(logic [15:0] s, int k, logic [15:0] t, bit wrap_b);
        logic [15:0] c;
        c = s;
        for (int i = 0; i < k; i++) c = (wrap_b && c == t) ? 16'd0 : c + 16'd1;
        return c;
    endfunction

    function automatic int wave_next(int st, logic [1:0] md, bit s, bit c, bit t);
        case (md)
            2'd0: return 0;
            2'd1: return c ? 0 : (s ? 1 : st);
            2'd2: return t ? ((st == 1) ? 0 : 1) : st;
            default: begin
                if (st == 0 && s) return 1;
                if (st == 1 && c) return 2;
                return st;
            end
        endcase
    endfunction

    function automatic logic wave_out(int st, logic [1:0] md, logic inv);
        return ((md != 2'd0) && (st == 1)) ^ inv;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        idle(3); rst_n = 1'b1; idle(1);

        // R1 reset state
        rd(3'd6, v); check("R1 count", v, 0);
        rd(3'd0, v); check("R1 ctrl", v, 0);
        rd(3'd4, v); check("R1 flags", v, 0);
        check("R1 tout_a", tout_a, 0);
        check("R1 tout_b", tout_b, 0);
        check("R1 irq", irq, 0);

        // R2 R5 random periods with internal tick
        wr(3'd1, 16'h0000);
        wr(3'd0, 16'h0001);
        for (int it = 0; it < 8; it++) begin
            top   = 16'($urandom_range(3, 20));
            start = 16'($urandom_range(0, top));
            n     = $urandom_range(0, 50);
            wr(3'd3, top);
            wr(3'd6, start);
            idle(1);
            tick(n);
            rd(3'd6, v); check("R2 R5 random tick count", v, exp_count(start, n, top, 1'b1));
        end

        // R2 run=0 holds count
        wr(3'd3, 16'hFFFF);
        wr(3'd6, 16'd40);
        wr(3'd0, 16'h0000); idle(2);
        tick(3);
        rd(3'd6, v); check("R2 stopped hold", v, 40);

        // R5 wrap at FFFF with slot B capturing
        wr(3'd1, 16'h0002);
        wr(3'd6, 16'hFFFE);
        wr(3'd0, 16'h0001); idle(2);
        tick(2);
        rd(3'd6, v); check("R5 full wrap", v, 0);
        wr(3'd1, 16'h0000);

        // R5 directed period
        wr(3'd3, 16'd4); wr(3'd6, 16'd0); idle(1);
        tick(5); rd(3'd6, v); check("R5 period end", v, 0);
        tick(7); rd(3'd6, v); check("R5 second period", v, 2);

        // R6 compare flags
        wr(3'd2, 16'd3); wr(3'd3, 16'd10); wr(3'd6, 16'd0);
        wr(3'd4, 16'h001F); idle(1);
        tick(3); rd(3'd4, v); check("R6 no match yet", v, 0);
        tick(1); rd(3'd4, v); check("R6 slot A match", v, 16'h01);
        tick(6); rd(3'd4, v); check("R6 before B match", v, 16'h01);
        rd(3'd6, v); check("R6 count at B", v, 10);
        tick(1); rd(3'd4, v); check("R6 slot B match", v, 16'h03);
        rd(3'd6, v); check("R6 wrap on B", v, 0);

        // R9 clear and interrupt masking
        wr(3'd4, 16'h0000); rd(3'd4, v); check("R9 write zero keeps", v, 16'h03);
        wr(3'd4, 16'h0001); rd(3'd4, v); check("R9 write one clears", v, 16'h02);
        check("R9 irq masked", irq, 0);
        wr(3'd5, 16'h0002); idle(1); check("R9 irq enabled", irq, 1);
        wr(3'd5, 16'h0001); idle(1); check("R9 irq other enable", irq, 0);
        wr(3'd5, 16'h0000); wr(3'd4, 16'h001F);

        // R4 sources 10 and 11
        wr(3'd2, 16'hFFFF); wr(3'd3, 16'hFFFF);
        wr(3'd6, 16'd9);
        wr(3'd0, 16'h0007); idle(2); tick(5);
        rd(3'd6, v); check("R4 source 11", v, 9);
        wr(3'd0, 16'h0005); idle(2); tick(4);
        rd(3'd6, v); check("R4 source 10", v, 9);

        // R3 external event counting
        wr(3'd6, 16'd0);
        wr(3'd0, 16'h0003); idle(2);
        n = $urandom_range(2, 9);
        pulse_ext(n);
        rd(3'd6, v); check("R3 event edges", v, 16'(n));
        tick(3);
        rd(3'd6, v); check("R3 internal tick ignored", v, 16'(n));
        @(negedge clk); ext_evt = 1'b1; idle(12); ext_evt = 1'b0; idle(4);
        rd(3'd6, v); check("R3 long level counts once", v, 16'(n + 1));

        // R10 debug gating
        wr(3'd0, 16'h0001); wr(3'd6, 16'd0);
        @(negedge clk); debug_halt = 1'b1; idle(2);
        tick(4); rd(3'd6, v); check("R10 debug freeze", v, 0);
        wr(3'd0, 16'h0009); idle(2);
        tick(4); rd(3'd6, v); check("R10 debug run", v, 4);
        @(negedge clk); debug_halt = 1'b0;

        // R11 sleep gating
        wr(3'd0, 16'h0011);
        @(negedge clk); sleep_req = 1'b1; idle(2);
        tick(5); rd(3'd6, v); check("R11 sleep freeze", v, 4);
        @(negedge clk); sleep_req = 1'b0; idle(2);
        tick(3); rd(3'd6, v); check("R11 resume", v, 7);
        wr(3'd0, 16'h0001);
        @(negedge clk); sleep_req = 1'b1; idle(2);
        tick(2); rd(3'd6, v); check("R11 sleep without stop", v, 9);
        @(negedge clk); sleep_req = 1'b0;

        // R7 capture on slot A then overrun
        wr(3'd1, 16'h0001);
        wr(3'd6, 16'h1234); wr(3'd4, 16'h001F); idle(2);
        pulse_cap();
        rd(3'd2, v); check("R7 capture A value", v, 16'h1234);
        rd(3'd4, v); check("R7 capture A flag", v, 16'h04);
        wr(3'd6, 16'h0055); pulse_cap();
        rd(3'd2, v); check("R7 second capture", v, 16'h0055);
        rd(3'd4, v); check("R7 overrun flag", v, 16'h14);

        // R7 capture on slot B
        wr(3'd1, 16'h0002); wr(3'd4, 16'h001F);
        wr(3'd6, 16'h0777); idle(2);
        pulse_cap();
        rd(3'd3, v); check("R7 capture B value", v, 16'h0777);
        rd(3'd2, v); check("R7 slot A untouched", v, 16'h0055);
        rd(3'd4, v); check("R7 capture B flag", v, 16'h08);

        // R8 both capture bits requested
        wr(3'd1, 16'h0003);
        rd(3'd1, v); check("R8 only A captures", v, 16'h0001);
        wr(3'd6, 16'h0100); wr(3'd3, 16'h0AAA); wr(3'd4, 16'h001F); idle(2);
        pulse_cap();
        rd(3'd3, v); check("R8 slot B not captured", v, 16'h0AAA);
        rd(3'd2, v); check("R8 slot A captured", v, 16'h0100);

        // R14 invert with mode off
        wr(3'd0, 16'h0000);
        wr(3'd1, 16'h0090); idle(2);
        check("R14 invert A off mode", tout_a, 1);
        check("R14 invert B off mode", tout_b, 1);

        // R13 directed one-shot
        wr(3'd1, 16'h006C);
        wr(3'd2, 16'd1); wr(3'd3, 16'd3); wr(3'd6, 16'd0);
        wr(3'd0, 16'h0001); idle(2);
        tick(2); check("R13 one-shot rises", tout_a, 1);
        tick(2); check("R13 one-shot falls", tout_a, 0);
        tick(6); check("R13 one-shot stays low", tout_a, 0);
        wr(3'd0, 16'h0000); idle(2);
        wr(3'd6, 16'd0); wr(3'd0, 16'h0001); idle(2);
        tick(2); check("R13 rearmed after stop", tout_a, 1);

        // R12 R13 R14 random waveform modes against step model
        for (int it = 0; it < 14; it++) begin
            ma = 2'($urandom_range(0, 3)); mb = 2'($urandom_range(0, 3));
            ia = 1'($urandom_range(0, 1)); ib = 1'($urandom_range(0, 1));
            if (it < 3) begin ma = 2'd1; mb = 2'd2; end
            va = 16'($urandom_range(0, 8));
            vb = 16'($urandom_range(int'(va) + 1, 12));
            wr(3'd0, 16'h0000); idle(2);
            wr(3'd1, {8'h00, ib, mb, ia, ma, 2'b00});
            wr(3'd2, va); wr(3'd3, vb); wr(3'd6, 16'd0);
            wr(3'd0, 16'h0001); idle(2);
            mc = 16'd0; sa = 0; sb = 0;
            check("R12 R14 start A", tout_a, wave_out(sa, ma, ia));
            check("R12 R14 start B", tout_b, wave_out(sb, mb, ib));
            for (int k = 0; k < 30; k++) begin
                tick(1);
                ea = (mc == va); eb = (mc == vb);
                sa = wave_next(sa, ma, ea, eb, ea);
                sb = wave_next(sb, mb, ea, eb, eb);
                mc = eb ? 16'd0 : mc + 16'd1;
                check("R12 R13 R14 wave A", tout_a, wave_out(sa, ma, ia));
                check("R12 R13 R14 wave B", tout_b, wave_out(sb, mb, ib));
            end
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule